// File: doc/BRIEF.md
# TSO Store Buffer with Store-to-Load Forwarding

This block sits between an in-order load/store issue port of one core and a single memory port. Retired stores are parked in a small queue and written to memory one at a time, oldest first, so every observer sees this core's stores in program order. Loads do not wait for the queue to empty: a load whose word address matches no parked store reads memory at once, and a load whose word address matches one or more parked stores takes the data of the youngest of them without touching memory. This yields total-store-order behaviour: the only reordering visible from outside is a younger load completing before older stores.

A third request port carries barrier operations. A full fence stops all later loads and stores until the queue has drained, then acknowledges. A locked swap also drains the queue first, then reads one word and writes a new value to it as two back-to-back memory accesses with nothing in between, and returns the old value with the acknowledge.

The sequencer has six states. SB_RUN accepts loads and stores; a barrier request moves it to SB_DRAIN. SB_DRAIN waits for an empty queue, then goes to SB_DONE for a fence or SB_LOCK_RD for a swap. SB_LOCK_RD issues the memory read, SB_LOCK_GET captures the read data, SB_LOCK_WR holds the write until memory accepts it and then goes to SB_DONE. SB_DONE raises the acknowledge for one cycle and returns to SB_RUN.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the queue is empty: st_ready and ld_ready are 1, and mw_valid, op_ack and ld_rsp_valid are 0.
- R2: Parked stores are presented on the memory write port oldest first; while mw_valid is 1 and mw_ready is 0, mw_addr and mw_data stay unchanged, and an entry leaves only on a cycle with both high.
- R3: The queue holds DEPTH (default 8) stores; st_ready is 0 while it is full, and a store offered then is not taken.
- R4: A load whose word address matches no parked store raises mr_valid with mr_addr equal to the load address in its accept cycle, and ld_rsp_valid rises in the next cycle with ld_rsp_data equal to the memory read data, even when other stores are parked.
- R5: Matching compares address bits [31:2] only; a matching load does not raise mr_valid and returns, one cycle after accept, the data of the youngest matching parked store.
- R6: When a store and a load are accepted in the same cycle, the load is treated as older and does not see that store's data.
- R7: A fence (op_valid=1, op_lock=0) holds st_ready and ld_ready at 0 from the cycle it is raised, and op_ack pulses for one cycle only after every parked store has been written.
- R8: A locked swap (op_valid=1, op_lock=1) drains the queue, reads op_addr, then writes op_wdata to op_addr with no other memory access between, holding the write until mw_ready, and returns the old word on op_rdata with the one-cycle op_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load accepted when high with ld_valid |
| ld_addr | input | 32 | Load byte address |
| ld_rsp_valid | output | 1 | Load result valid, one cycle after accept |
| ld_rsp_data | output | 32 | Load result |
| op_valid | input | 1 | Barrier request, held until op_ack |
| op_lock | input | 1 | 0 = fence, 1 = locked swap |
| op_addr | input | 32 | Swap byte address |
| op_wdata | input | 32 | Swap new value |
| op_ack | output | 1 | One-cycle completion pulse |
| op_rdata | output | 32 | Old value returned by a swap |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | 32 | Memory write address |
| mw_data | output | 32 | Memory write data |
| mr_valid | output | 1 | Memory read request |
| mr_addr | output | 32 | Memory read address |
| mr_data | input | 32 | Memory read data, valid the cycle after mr_valid |

## Verification
A full queue is swept with loads to every word of a small memory, each at an aligned and an unaligned byte address, which separates forwarded words from memory reads and shows that the byte offset is ignored. Repeated stores to one word tell youngest-entry selection from oldest, and a store and load issued together show which of the two counts as older. The queue is drained under a toggling write-ready to expose reordering or duplicated writes, and fences and swaps are issued with writes still parked and with the memory stalled, so that an early acknowledge, a leaked load or store, or a wrong old value becomes visible.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;

    typedef enum logic [2:0] {
        SB_RUN,
        SB_DRAIN,
        SB_LOCK_RD,
        SB_LOCK_GET,
        SB_LOCK_WR,
        SB_DONE
    } sb_state_e;

endpackage

// File: rtl/tso_sb_queue.sv
module tso_sb_queue #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int DEPTH    = 8,
    parameter int WORD_LSB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [AW-1:0] head_addr_o,
    output logic [DW-1:0] head_data_o,
    output logic          empty_o,
    output logic          full_o,
    input  logic [AW-1:0] look_addr_i,
    output logic          hit_o,
    output logic [DW-1:0] hit_data_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] slot;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= bump(wr_ptr);
            if (pop_i)  rd_ptr <= bump(rd_ptr);
            if (push_i && !pop_i)      count <= count + CW'(1);
            else if (pop_i && !push_i) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            addr_q[wr_ptr] <= push_addr_i;
            data_q[wr_ptr] <= push_data_i;
        end
    end

    assign empty_o     = (count == '0);
    assign full_o      = (count == CW'(DEPTH));
    assign head_addr_o = addr_q[rd_ptr];
    assign head_data_o = data_q[rd_ptr];

    // scan oldest to youngest; a later match overrides an earlier one
    always_comb begin
        hit_o      = 1'b0;
        hit_data_o = '0;
        slot       = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = PW'((int'(rd_ptr) + i) % DEPTH);
            if (i < int'(count) &&
                addr_q[slot][AW-1:WORD_LSB] == look_addr_i[AW-1:WORD_LSB]) begin
                hit_o      = 1'b1;
                hit_data_o = data_q[slot];
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R2

endmodule

// File: rtl/tso_sb_ctrl.sv
module tso_sb_ctrl
    import tso_sb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid_i,
    input  logic          op_lock_i,
    input  logic [AW-1:0] op_addr_i,
    input  logic [DW-1:0] op_wdata_i,
    input  logic          empty_i,
    input  logic          mw_ready_i,
    input  logic [DW-1:0] mr_data_i,
    output logic          run_o,
    output logic          lock_rd_o,
    output logic          lock_wr_o,
    output logic [AW-1:0] lock_addr_o,
    output logic [DW-1:0] lock_wdata_o,
    output logic          op_ack_o,
    output logic [DW-1:0] op_rdata_o
);

    sb_state_e     state_q, state_d;
    logic          lock_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SB_RUN;
            lock_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SB_RUN && op_valid_i) begin
                lock_q  <= op_lock_i;
                addr_q  <= op_addr_i;
                wdata_q <= op_wdata_i;
            end
            if (state_q == SB_LOCK_GET) rdata_q <= mr_data_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_RUN:      if (op_valid_i) state_d = SB_DRAIN;
            SB_DRAIN:    if (empty_i) state_d = lock_q ? SB_LOCK_RD : SB_DONE;
            SB_LOCK_RD:  state_d = SB_LOCK_GET;
            SB_LOCK_GET: state_d = SB_LOCK_WR;
            SB_LOCK_WR:  if (mw_ready_i) state_d = SB_DONE;
            SB_DONE:     state_d = SB_RUN;
            default:     state_d = SB_RUN;
        endcase
    end

    always_comb begin
        run_o     = 1'b0;
        lock_rd_o = 1'b0;
        lock_wr_o = 1'b0;
        op_ack_o  = 1'b0;
        unique case (state_q)
            SB_RUN:      run_o     = 1'b1;
            SB_DRAIN:    ;
            SB_LOCK_RD:  lock_rd_o = 1'b1;
            SB_LOCK_GET: ;
            SB_LOCK_WR:  lock_wr_o = 1'b1;
            SB_DONE:     op_ack_o  = 1'b1;
            default:     ;
        endcase
    end

    assign lock_addr_o  = addr_q;
    assign lock_wdata_o = wdata_q;
    assign op_rdata_o   = rdata_q;

    AST_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        op_ack_o |-> empty_i); // R7
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_ack_o |=> !op_ack_o); // R7
    AST_LOCK_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr_o && !mw_ready_i |=> lock_wr_o && $stable(lock_addr_o)); // R8

endmodule

// File: rtl/tso_sb_load.sv
module tso_sb_load #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic          hit_i,
    input  logic [DW-1:0] hit_data_i,
    input  logic [DW-1:0] mr_data_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_data_o
);

    logic          valid_q;
    logic          hit_q;
    logic [DW-1:0] fwd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            hit_q   <= 1'b0;
            fwd_q   <= '0;
        end else begin
            valid_q <= fire_i;
            if (fire_i) begin
                hit_q <= hit_i;
                fwd_q <= hit_data_i;
            end
        end
    end

    assign rsp_valid_o = valid_q;
    assign rsp_data_o  = hit_q ? fwd_q : mr_data_i;

    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> rsp_valid_o); // R4

endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data,
    input  logic          op_valid,
    input  logic          op_lock,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_wdata,
    output logic          op_ack,
    output logic [DW-1:0] op_rdata,
    output logic          mw_valid,
    input  logic          mw_ready,
    output logic [AW-1:0] mw_addr,
    output logic [DW-1:0] mw_data,
    output logic          mr_valid,
    output logic [AW-1:0] mr_addr,
    input  logic [DW-1:0] mr_data
);

    localparam int WORD_LSB = $clog2(DW / 8);

    logic          run, lock_rd, lock_wr;
    logic [AW-1:0] lock_addr;
    logic [DW-1:0] lock_wdata;
    logic          q_empty, q_full, q_push, q_pop, q_hit;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data, hit_data;
    logic          ld_fire;

    assign st_ready = run && !op_valid && !q_full;
    assign ld_ready = run && !op_valid;
    assign q_push   = st_valid && st_ready;
    assign ld_fire  = ld_valid && ld_ready;
    assign q_pop    = !q_empty && !lock_wr && mw_ready;

    assign mw_valid = lock_wr || !q_empty;
    assign mw_addr  = lock_wr ? lock_addr  : head_addr;
    assign mw_data  = lock_wr ? lock_wdata : head_data;
    assign mr_valid = lock_rd || (ld_fire && !q_hit);
    assign mr_addr  = lock_rd ? lock_addr : ld_addr;

    tso_sb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .WORD_LSB(WORD_LSB)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (q_push),
        .push_addr_i (st_addr),
        .push_data_i (st_data),
        .pop_i       (q_pop),
        .head_addr_o (head_addr),
        .head_data_o (head_data),
        .empty_o     (q_empty),
        .full_o      (q_full),
        .look_addr_i (ld_addr),
        .hit_o       (q_hit),
        .hit_data_o  (hit_data)
    );

    tso_sb_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid_i   (op_valid),
        .op_lock_i    (op_lock),
        .op_addr_i    (op_addr),
        .op_wdata_i   (op_wdata),
        .empty_i      (q_empty),
        .mw_ready_i   (mw_ready),
        .mr_data_i    (mr_data),
        .run_o        (run),
        .lock_rd_o    (lock_rd),
        .lock_wr_o    (lock_wr),
        .lock_addr_o  (lock_addr),
        .lock_wdata_o (lock_wdata),
        .op_ack_o     (op_ack),
        .op_rdata_o   (op_rdata)
    );

    tso_sb_load #(.DW(DW)) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (ld_fire),
        .hit_i       (q_hit),
        .hit_data_i  (hit_data),
        .mr_data_i   (mr_data),
        .rsp_valid_o (ld_rsp_valid),
        .rsp_data_o  (ld_rsp_data)
    );

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data)); // R2
    AST_BARRIER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ack |-> !st_ready && !ld_ready); // R7
    AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_rd |-> !mw_valid); // R8

endmodule

// File: tb/tso_store_buffer_bench.sv
module tso_store_buffer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, ld_valid = 1'b0, op_valid = 1'b0, op_lock = 1'b0;
    logic        mw_ready = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0, op_addr = '0, op_wdata = '0;
    logic        st_ready, ld_ready, ld_rsp_valid, op_ack, mw_valid, mr_valid;
    logic [31:0] ld_rsp_data, op_rdata, mw_addr, mw_data, mr_addr;
    logic [31:0] mr_data;

    logic [31:0] mem [16];
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_n;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tso_store_buffer u_tso_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .op_valid(op_valid), .op_lock(op_lock), .op_addr(op_addr), .op_wdata(op_wdata),
        .op_ack(op_ack), .op_rdata(op_rdata),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
        .mr_valid(mr_valid), .mr_addr(mr_addr), .mr_data(mr_data)
    );

    // memory model: one-cycle read, write on handshake, write log
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hA000 + 32'(i);
            log_n   <= 0;
            mr_data <= '0;
        end else begin
            if (mr_valid) mr_data <= mem[mr_addr[5:2]];
            if (mw_valid && mw_ready) begin
                mem[mw_addr[5:2]] <= mw_data;
                log_addr[log_n]   <= mw_addr;
                log_data[log_n]   <= mw_data;
                log_n             <= log_n + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_load(input string req, input logic [31:0] a,
                           input logic [31:0] exp, input bit from_mem);
        ld_valid = 1'b1; ld_addr = a;
        #1;
        chk({req, " mr_valid"}, {31'b0, mr_valid}, {31'b0, from_mem});
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        chk({req, " rsp_valid"}, {31'b0, ld_rsp_valid}, 32'd1);
        chk({req, " rsp_data"}, ld_rsp_data, exp);
    endtask

    task automatic wait_ack();
        for (int i = 0; i < 100 && !op_ack; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 st_ready", {31'b0, st_ready}, 32'd1);
        chk("R1 ld_ready", {31'b0, ld_ready}, 32'd1);
        chk("R1 mw_valid", {31'b0, mw_valid}, 32'd0);
        chk("R1 op_ack", {31'b0, op_ack}, 32'd0);
        chk("R1 ld_rsp_valid", {31'b0, ld_rsp_valid}, 32'd0);

        // fill the queue with memory stalled (R3)
        for (int k = 0; k < 8; k++) do_store(32'(k * 4), 32'h100 + 32'(k));
        chk("R3 full st_ready", {31'b0, st_ready}, 32'd0);
        chk("R2 head addr", mw_addr, 32'h0);
        st_valid = 1'b1; st_addr = 32'h3C; st_data = 32'hDEAD;
        repeat (2) @(negedge clk);
        st_valid = 1'b0;

        // R4/R5 sweep: every word, aligned and offset by 3
        for (int w = 0; w < 16; w++) begin
            for (int o = 0; o < 4; o += 3) begin
                if (w < 8) do_load("R5 fwd", 32'(w * 4 + o), 32'h100 + 32'(w), 1'b0);
                else       do_load("R4 pass", 32'(w * 4 + o), 32'hA000 + 32'(w), 1'b1);
            end
        end

        // drain under toggling ready (R2)
        for (int c = 0; c < 24; c++) begin
            mw_ready = ~mw_ready;
            @(negedge clk);
        end
        mw_ready = 1'b0;
        chk("R3 dropped store", 32'(log_n), 32'd8);
        for (int k = 0; k < 8; k++) begin
            chk("R2 order addr", log_addr[k], 32'(k * 4));
            chk("R2 order data", log_data[k], 32'h100 + 32'(k));
        end
        chk("R2 empty", {31'b0, mw_valid}, 32'd0);

        // youngest match (R5)
        do_store(32'h8, 32'h1);
        do_store(32'hC, 32'h2);
        do_store(32'h8, 32'h3);
        do_load("R5 youngest", 32'h8, 32'h3, 1'b0);
        do_load("R5 single", 32'hE, 32'h2, 1'b0);

        // same-cycle store and load (R6)
        st_valid = 1'b1; st_addr = 32'h10; st_data = 32'h55;
        ld_valid = 1'b1; ld_addr = 32'h10;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0; ld_valid = 1'b0;
        chk("R6 older load", ld_rsp_data, 32'h104);
        do_load("R6 later load", 32'h10, 32'h55, 1'b0);

        // fence with four parked stores (R7)
        base = log_n;
        op_valid = 1'b1; op_lock = 1'b0;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk("R7 ld blocked", {31'b0, ld_ready}, 32'd0);
            chk("R7 st blocked", {31'b0, st_ready}, 32'd0);
            chk("R7 no early ack", {31'b0, op_ack}, 32'd0);
            @(negedge clk);
        end
        mw_ready = 1'b1;
        wait_ack();
        chk("R7 ack", {31'b0, op_ack}, 32'd1);
        chk("R7 drained", 32'(log_n - base), 32'd4);
        chk("R7 last write", log_data[log_n - 1], 32'h55);
        chk("R7 mw idle", {31'b0, mw_valid}, 32'd0);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R7 resume", {31'b0, ld_ready}, 32'd1);

        // locked swap after a parked store (R8)
        mw_ready = 1'b0;
        do_store(32'h14, 32'h77);
        base = log_n;
        op_valid = 1'b1; op_lock = 1'b1; op_addr = 32'h14; op_wdata = 32'h99;
        repeat (3) @(negedge clk);
        mw_ready = 1'b1;
        wait_ack();
        chk("R8 ack", {31'b0, op_ack}, 32'd1);
        chk("R8 old value", op_rdata, 32'h77);
        chk("R8 writes", 32'(log_n - base), 32'd2);
        chk("R8 swap data", log_data[log_n - 1], 32'h99);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R8 memory", mem[5], 32'h99);

        // second swap with the write stalled (R8)
        base = log_n;
        mw_ready = 1'b0;
        op_valid = 1'b1; op_addr = 32'h17; op_wdata = 32'hAB;
        repeat (6) @(negedge clk);
        chk("R8 stalled no ack", {31'b0, op_ack}, 32'd0);
        chk("R8 stalled write addr", mw_addr, 32'h17);
        mw_ready = 1'b1;
        wait_ack();
        chk("R8 stalled old", op_rdata, 32'h99);
        chk("R8 stalled writes", 32'(log_n - base), 32'd1);
        op_valid = 1'b0; op_lock = 1'b0;
        @(negedge clk);
        do_load("R4 after swap", 32'h14, 32'hAB, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule